// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block moves a microcontroller between its operating modes when software asks for a change. Software writes a 4-bit target-mode code through a one-cycle write strobe. The controller checks the request against the current mode and against the interrupt and wakeup lines that are pending when the write arrives. It then commits the change, abandons it without notice, or rejects it and pulses an invalid-mode interrupt. Two low-power targets exist. The light halt mode gates the core clock. The deeper stop mode also turns the system PLL off.

The current mode is kept as a 4-bit code on `mode_o`. A committed change takes one busy cycle before the new mode is reported. From halt or stop, a wake input returns the device to the run mode it left. On the way back the PLL is enabled one cycle before the core clock gate opens. The core clock enable, the PLL enable and the flash power state are decoded from the mode, and from per-mode flash settings for the two low-power modes.

Mode codes: SAFE 4'b0010, DRUN 4'b0011, RUN0..RUN3 4'b0100..4'b0111, HALT 4'b1000, STOP 4'b1010. Flash power codes: 2'b00 normal, 2'b01 low-power, 2'b11 power-down.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any edge that samples `sys_reset` high, `mode_o` is DRUN (4'b0011) and `busy_o` is 0. `sys_reset` overrides every other input and cancels any change in progress.
- R2: From a run mode (4'b0100..4'b0111), a write of 4'b1000 with `irq_pend` low raises `busy_o` for exactly one cycle while `mode_o` still shows the source mode. After that cycle `mode_o` becomes HALT (4'b1000). A pending wakeup does not stop a halt request.
- R3: From a run mode, a write of 4'b1010 with both `irq_pend` and `wkup_pend` low follows the same one-busy-cycle sequence into STOP (4'b1010).
- R4: A halt request from a run mode that is sampled with `irq_pend` high is abandoned. `mode_o` is unchanged, `busy_o` stays 0 and `invalid_irq_o` stays 0.
- R5: A stop request from a run mode that is sampled with `irq_pend` or `wkup_pend` high is abandoned in the same way as in R4.
- R6: An edge that samples `safe_req` high while `sys_reset` is low puts the controller in SAFE (4'b0010) with `busy_o` 0 on the next cycle. This applies in every state, including a write that would otherwise be abandoned, and it raises no invalid-mode pulse.
- R7: Any other write is ignored and sets `invalid_irq_o` high for the one cycle after the write edge. This covers a low-power code written from a non-run mode, an undefined code, any write in SAFE, HALT or STOP, and any write while `busy_o` is high.
- R8: A run-mode code (4'b0100..4'b0111) written from DRUN or from a run mode takes one busy cycle and then becomes the current mode.
- R9: In steady HALT, `core_clk_en_o` is 0 and `pll_en_o` is 1. `flash_pwr_o` follows `halt_flash_cfg`: 2'b00, 2'b01 and 2'b11 pass through, and 2'b10 gives 2'b00.
- R10: In steady STOP, `core_clk_en_o` and `pll_en_o` are both 0. `flash_pwr_o` is 2'b11 when `stop_flash_pd` is 1 and 2'b00 otherwise, so it is never low-power.
- R11: `wake` sampled high in steady HALT or STOP gives one busy cycle with `pll_en_o` 1, `core_clk_en_o` 0 and `mode_o` still the low-power code. The controller then returns to the run mode it came from with the core clock on. `wake` has no effect in any other state.
- R12: In every other state (DRUN, SAFE, the run modes, and the busy cycle of a write), `core_clk_en_o` and `pll_en_o` are 1 and `flash_pwr_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for a mode request |
| wr_code | input | 4 | Requested target-mode code |
| irq_pend | input | 1 | Some interrupt request is active |
| wkup_pend | input | 1 | Some wakeup event is active |
| safe_req | input | 1 | Safe-mode request |
| sys_reset | input | 1 | Functional reset event, forces DRUN |
| wake | input | 1 | Leave halt or stop |
| halt_flash_cfg | input | 2 | Flash power setting used in halt |
| stop_flash_pd | input | 1 | Power down the flash in stop |
| mode_o | output | 4 | Current mode code |
| busy_o | output | 1 | A mode change is in progress |
| invalid_irq_o | output | 1 | Pulse for a rejected request |
| core_clk_en_o | output | 1 | Core clock gate enable |
| pll_en_o | output | 1 | System PLL enable |
| flash_pwr_o | output | 2 | Flash power state |

## Verification
The properties assume that every input is synchronous to `clk` and is held steady around each rising edge. They also assume that `wr_code` matters only when `wr_en` is high, and that `rst_n` starts low at time zero. The bench changes every input only on the falling edge and starts with reset asserted. It drives the write strobe for single cycles, except in one case where it holds the strobe for two cycles on purpose to hit the write-while-busy rule. Abort checks hold the interrupt, wakeup and safe lines steady across the write edge, so each abort cause is seen on its own and also in combination with the safe and reset inputs.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int MODE_W = 4;
    localparam int FL_W   = 2;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [FL_W-1:0]   flash_t;

    localparam mode_t M_SAFE = 4'b0010;
    localparam mode_t M_DRUN = 4'b0011;
    localparam mode_t M_RUN0 = 4'b0100;
    localparam mode_t M_HALT = 4'b1000;
    localparam mode_t M_STOP = 4'b1010;

    localparam flash_t FL_NORM = 2'b00;
    localparam flash_t FL_LOW  = 2'b01;
    localparam flash_t FL_PD   = 2'b11;

    typedef enum logic [1:0] {PH_STEADY, PH_TRANS, PH_WAKE} phase_t;

    typedef struct packed {
        phase_t phase;
        mode_t  mode;
        mode_t  tgt;
        mode_t  ret;
        logic   inv;
    } ctl_t;

    // run modes share the two upper bits 2'b01
    function automatic logic is_run(mode_t m);
        return m[MODE_W-1 -: 2] == 2'b01;
    endfunction
endpackage

// File: rtl/lpm_req_decode.sv
module lpm_req_decode
    import lpm_pkg::*;
(
    input  mode_t cur,
    input  mode_t code,
    input  logic  irq,
    input  logic  wkup,
    output logic  go,
    output logic  abort
);
    logic src_run, want_halt, want_stop, lp_ok, run_ok;

    always_comb begin
        src_run   = is_run(cur);
        want_halt = (code == M_HALT);
        want_stop = (code == M_STOP);
        lp_ok     = src_run && (want_halt || want_stop);
        abort     = lp_ok && (irq || (want_stop && wkup));
        run_ok    = is_run(code) && (src_run || cur == M_DRUN);
        go        = (lp_ok && !abort) || run_ok;
    end
endmodule

// File: rtl/lpm_pwr_out.sv
module lpm_pwr_out
    import lpm_pkg::*;
(
    input  phase_t phase,
    input  mode_t  mode,
    input  flash_t halt_cfg,
    input  logic   stop_pd,
    output logic   core_en,
    output logic   pll_en,
    output flash_t flash
);
    always_comb begin
        core_en = 1'b1;
        pll_en  = 1'b1;
        flash   = FL_NORM;
        if (phase == PH_WAKE) begin
            core_en = 1'b0;
        end else if (phase == PH_STEADY && mode == M_HALT) begin
            core_en = 1'b0;
            flash   = (halt_cfg == FL_LOW || halt_cfg == FL_PD) ? halt_cfg : FL_NORM;
        end else if (phase == PH_STEADY && mode == M_STOP) begin
            core_en = 1'b0;
            pll_en  = 1'b0;
            flash   = stop_pd ? FL_PD : FL_NORM;
        end
    end
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
    import lpm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   wr_code,
    input  logic         irq_pend,
    input  logic         wkup_pend,
    input  logic         safe_req,
    input  logic         sys_reset,
    input  logic         wake,
    input  logic [1:0]   halt_flash_cfg,
    input  logic         stop_flash_pd,
    output logic [3:0]   mode_o,
    output logic         busy_o,
    output logic         invalid_irq_o,
    output logic         core_clk_en_o,
    output logic         pll_en_o,
    output logic [1:0]   flash_pwr_o
);
    localparam ctl_t CTL_RST = '{phase: PH_STEADY, mode: M_DRUN, tgt: M_DRUN,
                                 ret: M_RUN0, inv: 1'b0};

    ctl_t ctl_d, ctl_q;
    logic req_go, req_abort;

    lpm_req_decode u_dec (
        .cur   (ctl_q.mode),
        .code  (wr_code),
        .irq   (irq_pend),
        .wkup  (wkup_pend),
        .go    (req_go),
        .abort (req_abort)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.inv = 1'b0;
        if (sys_reset) begin
            ctl_d = CTL_RST;
        end else if (safe_req) begin
            ctl_d.phase = PH_STEADY;
            ctl_d.mode  = M_SAFE;
        end else begin
            case (ctl_q.phase)
                PH_TRANS: begin
                    ctl_d.phase = PH_STEADY;
                    ctl_d.mode  = ctl_q.tgt;
                    ctl_d.inv   = wr_en;
                end
                PH_WAKE: begin
                    ctl_d.phase = PH_STEADY;
                    ctl_d.mode  = ctl_q.ret;
                    ctl_d.inv   = wr_en;
                end
                default: begin
                    if (wr_en) begin
                        if (req_go) begin
                            ctl_d.phase = PH_TRANS;
                            ctl_d.tgt   = wr_code;
                            if (!is_run(wr_code)) ctl_d.ret = ctl_q.mode;
                        end else if (!req_abort) begin
                            ctl_d.inv = 1'b1;
                        end
                    end
                    if (wake && (ctl_q.mode == M_HALT || ctl_q.mode == M_STOP))
                        ctl_d.phase = PH_WAKE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    lpm_pwr_out u_pwr (
        .phase    (ctl_q.phase),
        .mode     (ctl_q.mode),
        .halt_cfg (halt_flash_cfg),
        .stop_pd  (stop_flash_pd),
        .core_en  (core_clk_en_o),
        .pll_en   (pll_en_o),
        .flash    (flash_pwr_o)
    );

    assign mode_o        = ctl_q.mode;
    assign busy_o        = (ctl_q.phase != PH_STEADY);
    assign invalid_irq_o = ctl_q.inv;
endmodule

// File: rtl/lpm_entry_chk.sv
module lpm_entry_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_code,
    input logic       irq_pend,
    input logic       wkup_pend,
    input logic       safe_req,
    input logic       sys_reset,
    input logic [3:0] mode_o,
    input logic       busy_o,
    input logic       invalid_irq_o,
    input logic       core_clk_en_o,
    input logic       pll_en_o,
    input logic [1:0] flash_pwr_o
);
    logic steady_run, halt_abort, stop_abort;
    assign steady_run = !busy_o && is_run(mode_o);
    assign halt_abort = wr_en && steady_run && wr_code == M_HALT && irq_pend;
    assign stop_abort = wr_en && steady_run && wr_code == M_STOP && (irq_pend || wkup_pend);

    AST_RESET_DRUN: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> (mode_o == M_DRUN && !busy_o)); // R1
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o); // R2
    AST_HALT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_abort && !safe_req && !sys_reset) |=> (!invalid_irq_o && !busy_o && $stable(mode_o))); // R4
    AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_abort && !safe_req && !sys_reset) |=> (!invalid_irq_o && !busy_o && $stable(mode_o))); // R5
    AST_SAFE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_req && !sys_reset) |=> (mode_o == M_SAFE && !busy_o && !invalid_irq_o)); // R6
    AST_SAFE_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy_o && mode_o == M_SAFE && !safe_req && !sys_reset) |=> invalid_irq_o); // R7
    AST_HALT_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && mode_o == M_HALT) |-> (!core_clk_en_o && pll_en_o)); // R9
    AST_STOP_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && mode_o == M_STOP) |-> (!core_clk_en_o && !pll_en_o && flash_pwr_o != FL_LOW)); // R10
    AST_PLL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_clk_en_o) && !$past(sys_reset) && !$past(safe_req)) |-> $past(pll_en_o)); // R11
    AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (is_run(mode_o) || mode_o == M_DRUN || mode_o == M_SAFE))
        |-> (core_clk_en_o && pll_en_o && flash_pwr_o == FL_NORM)); // R12
endmodule

bind lpm_entry_ctrl lpm_entry_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_code       (wr_code),
    .irq_pend      (irq_pend),
    .wkup_pend     (wkup_pend),
    .safe_req      (safe_req),
    .sys_reset     (sys_reset),
    .mode_o        (mode_o),
    .busy_o        (busy_o),
    .invalid_irq_o (invalid_irq_o),
    .core_clk_en_o (core_clk_en_o),
    .pll_en_o      (pll_en_o),
    .flash_pwr_o   (flash_pwr_o)
);

// File: tb/sim_lpm_entry_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_entry_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, irq_pend = 0, wkup_pend = 0, safe_req = 0, sys_reset = 0, wake = 0;
    logic stop_flash_pd = 0;
    logic [3:0] wr_code = 0;
    logic [1:0] halt_flash_cfg = 0;
    logic [3:0] mode_o;
    logic busy_o, invalid_irq_o, core_clk_en_o, pll_en_o;
    logic [1:0] flash_pwr_o;

    always #2 clk = ~clk;

    lpm_entry_ctrl u0 (.*);

    int checks = 0, errors = 0;
    string tag = "R1";

    // behavioural reference: mode number, phase 0 steady / 1 changing / 2 waking
    int m_mode = 3, m_phase = 0, m_tgt = 3, m_ret = 4, m_inv = 0;

    function automatic bit runm(int m); return m >= 4 && m <= 7; endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 3; m_phase = 0; m_tgt = 3; m_ret = 4; m_inv = 0;
        end else begin
            int code;
            code = wr_code;
            m_inv = 0;
            if (sys_reset) begin m_mode = 3; m_phase = 0; m_tgt = 3; m_ret = 4; end
            else if (safe_req) begin m_mode = 2; m_phase = 0; end
            else if (m_phase != 0) begin
                m_mode = (m_phase == 1) ? m_tgt : m_ret;
                m_phase = 0;
                if (wr_en) m_inv = 1;
            end else begin
                if (wr_en) begin
                    if (runm(m_mode) && code == 8) begin
                        if (!irq_pend) begin m_phase = 1; m_tgt = 8; m_ret = m_mode; end
                    end else if (runm(m_mode) && code == 10) begin
                        if (!irq_pend && !wkup_pend) begin m_phase = 1; m_tgt = 10; m_ret = m_mode; end
                    end else if ((runm(m_mode) || m_mode == 3) && runm(code)) begin
                        m_phase = 1; m_tgt = code;
                    end else m_inv = 1;
                end
                if (wake && (m_mode == 8 || m_mode == 10)) m_phase = 2;
            end
        end
    end

    task automatic chk(string t, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int ec = 1, ep = 1, ef = 0;
        if (m_phase == 2) ec = 0;
        else if (m_phase == 0 && m_mode == 8) begin
            ec = 0;
            ef = (halt_flash_cfg == 2'b10) ? 0 : halt_flash_cfg;
        end else if (m_phase == 0 && m_mode == 10) begin
            ec = 0; ep = 0; ef = stop_flash_pd ? 3 : 0;
        end
        chk(tag, mode_o, m_mode, "mode");
        chk(tag, busy_o, m_phase != 0, "busy");
        chk(tag, invalid_irq_o, m_inv, "invalid_irq");
        chk(tag, core_clk_en_o, ec, "core_clk_en");
        chk(tag, pll_en_o, ep, "pll_en");
        chk(tag, flash_pwr_o, ef, "flash");
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
        compare();
    endtask

    task automatic wr(int c);
        wr_en = 1; wr_code = 4'(c);
        tick();
        wr_en = 0;
    endtask

    task automatic outs(string t, int c, int p, int f);
        chk(t, core_clk_en_o, c, "core_clk_en");
        chk(t, pll_en_o, p, "pll_en");
        chk(t, flash_pwr_o, f, "flash");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1", mode_o, 3, "mode in reset");
        rst_n = 1;
        tick();
        chk("R1", mode_o, 3, "mode after reset"); chk("R1", busy_o, 0, "busy");

        tag = "R7"; wr(8);
        chk("R7", invalid_irq_o, 1, "halt from DRUN"); chk("R7", mode_o, 3, "mode");
        tick(); chk("R7", invalid_irq_o, 0, "pulse end");

        tag = "R8"; wr(5);
        chk("R8", busy_o, 1, "busy"); chk("R8", mode_o, 3, "source shown");
        tick(); chk("R8", mode_o, 5, "RUN1");
        tag = "R12"; outs("R12", 1, 1, 0);

        tag = "R2"; halt_flash_cfg = 2'b01; wr(8);
        chk("R2", busy_o, 1, "busy"); chk("R2", mode_o, 5, "source shown");
        tick(); chk("R2", mode_o, 8, "halt");
        tag = "R9"; outs("R9", 0, 1, 1);
        halt_flash_cfg = 2'b10; tick(); outs("R9", 0, 1, 0);
        halt_flash_cfg = 2'b11; tick(); outs("R9", 0, 1, 3);
        tag = "R11"; wake = 1; tick(); wake = 0;
        chk("R11", busy_o, 1, "busy"); chk("R11", mode_o, 8, "mode"); outs("R11", 0, 1, 0);
        tick(); chk("R11", mode_o, 5, "back to RUN1"); outs("R11", 1, 1, 0);

        tag = "R3"; stop_flash_pd = 1; wr(10);
        chk("R3", busy_o, 1, "busy");
        tick(); chk("R3", mode_o, 10, "stop");
        tag = "R10"; outs("R10", 0, 0, 3);
        stop_flash_pd = 0; tick(); outs("R10", 0, 0, 0);
        tag = "R11"; wake = 1; tick(); wake = 0;
        outs("R11", 0, 1, 0);
        tick(); chk("R11", mode_o, 5, "back from stop"); outs("R11", 1, 1, 0);

        tag = "R4"; irq_pend = 1; wr(8);
        chk("R4", mode_o, 5, "kept"); chk("R4", busy_o, 0, "busy"); chk("R4", invalid_irq_o, 0, "no inv");
        irq_pend = 0; tick();
        tag = "R2"; wkup_pend = 1; wr(8); wkup_pend = 0;
        tick(); chk("R2", mode_o, 8, "halt despite wakeup");
        wake = 1; tick(); wake = 0; tick();

        tag = "R5"; wkup_pend = 1; wr(10);
        chk("R5", mode_o, 5, "wakeup abort"); chk("R5", invalid_irq_o, 0, "no inv");
        wkup_pend = 0; irq_pend = 1; wr(10);
        chk("R5", mode_o, 5, "irq abort"); chk("R5", busy_o, 0, "busy"); chk("R5", invalid_irq_o, 0, "no inv");
        irq_pend = 0;

        tag = "R6"; irq_pend = 1; safe_req = 1; wr(8);
        chk("R6", mode_o, 2, "safe on abort"); chk("R6", invalid_irq_o, 0, "no inv");
        safe_req = 0; irq_pend = 0;
        tag = "R7"; wr(5);
        chk("R7", invalid_irq_o, 1, "write in SAFE"); chk("R7", mode_o, 2, "mode");
        tag = "R1"; sys_reset = 1; tick(); sys_reset = 0;
        chk("R1", mode_o, 3, "DRUN from SAFE");
        tag = "R8"; wr(4); tick(); chk("R8", mode_o, 4, "RUN0");

        tag = "R1"; irq_pend = 1; sys_reset = 1; wr(10);
        chk("R1", mode_o, 3, "DRUN on abort with reset"); chk("R1", invalid_irq_o, 0, "no inv");
        irq_pend = 0; sys_reset = 0;
        tag = "R8"; wr(6); tick(); chk("R8", mode_o, 6, "RUN2");

        tag = "R7"; wr(15); chk("R7", invalid_irq_o, 1, "undefined 1111"); chk("R7", mode_o, 6, "mode");
        wr(9); chk("R7", invalid_irq_o, 1, "undefined 1001");
        wr_en = 1; wr_code = 4'd7; tick(); tick(); wr_en = 0;
        chk("R7", invalid_irq_o, 1, "write while busy"); chk("R7", mode_o, 7, "RUN3");

        tag = "R1"; wr(8); sys_reset = 1; tick(); sys_reset = 0;
        chk("R1", mode_o, 3, "reset in transition"); chk("R1", busy_o, 0, "busy");

        tag = "R6"; wr(4); tick(); wr(8); tick();
        safe_req = 1; tick(); safe_req = 0;
        chk("R6", mode_o, 2, "safe from halt"); outs("R6", 1, 1, 0);
        sys_reset = 1; tick(); sys_reset = 0;

        tag = "R11"; wr(7); tick(); wake = 1; tick(); wake = 0;
        chk("R11", busy_o, 0, "wake ignored in run"); chk("R11", mode_o, 7, "mode");
        repeat (4) tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule